// File: doc/BRIEF.md
# Lane-Parallel Saturating Rounding Doubling Multiply-High Unit

This unit multiplies two vectors of signed fixed-point values lane by lane. In each lane it doubles the full product, adds half of one element's weight as a rounding term, and keeps the upper element-sized half of the sum. Any lane result that falls outside the signed element range is clamped. Lanes are 16 or 32 bits wide. The vector is 64 or 128 bits, so one operation covers 2, 4 or 8 lanes.

The second operand can also be used in broadcast form. In that case one element, taken by index from the low 64 bits of the second operand, feeds every lane. Each result carries a flag that says whether any lane clamped. A sticky flag collects these events until it is cleared or the unit is reset. The arithmetic condition flags of the surrounding datapath are not touched.

The unit is a two-stage pipeline with no backpressure. Operand selection and the capture of the inputs happen in the first stage. The lane arithmetic and the output registers form the second stage.

Top module: `qrdmh_unit`

## Requirements
- R1: With `size_sel` = 2'b01, each active 16-bit lane i (bits 16i+15..16i) of `out_vec` equals (2*a*b + 2^15) arithmetically shifted right by 16, where a and b are the signed lane values, clamped to [-32768, 32767].
- R2: With `size_sel` = 2'b10, each active 32-bit lane i (bits 32i+31..32i) of `out_vec` equals (2*a*b + 2^31) arithmetically shifted right by 32, clamped to the signed 32-bit range.
- R3: A lane clamps only when both of its operands are the most negative value. It then yields the most positive value. `out_sat` is 1 exactly when some active lane of a legal operation clamped.
- R4: With `wide_sel` = 0, only lanes inside bits 63..0 are active. `out_vec[127:64]` reads zero, and clamping in the upper lanes does not affect `out_sat` or `sat_sticky`.
- R5: With `scalar_en` = 1, every lane takes its b operand from one element of `op_b[63:0]`. For 16-bit lanes this element is bits 16k+15..16k with k = `scalar_idx`. For 32-bit lanes it is bits 32k+31..32k with k = `scalar_idx[0]`.
- R6: `sat_sticky` is set in the cycle that `out_sat` is presented with value 1. No operation ever clears it.
- R7: `sat_sticky` is cleared by reset or by `sat_clr` at a clock edge. When a clamping result registers in the same cycle as the clear, the bit ends up set.
- R8: A `size_sel` of 2'b00 or 2'b11 produces `out_bad_size` = 1, `out_vec` = 0 and `out_sat` = 0, and leaves `sat_sticky` unchanged.
- R9: `out_valid` and the matching result appear exactly two clock edges after an edge at which `in_valid` was sampled high. `out_valid` is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector or scalar source |
| size_sel | input | 2 | Element size code: 01 for 16-bit, 10 for 32-bit |
| wide_sel | input | 1 | 1 for a 128-bit vector, 0 for a 64-bit vector |
| scalar_en | input | 1 | Broadcast one element of op_b to every lane |
| scalar_idx | input | 2 | Element index for broadcast |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Result vector |
| out_sat | output | 1 | Some lane of this result clamped |
| out_bad_size | output | 1 | This result had an illegal size code |
| sat_sticky | output | 1 | Cumulative clamp flag |

## Verification
The assertions take `in_valid` to be a clean synchronous strobe, driven low throughout reset, and `sat_clr` to be sampled at the same edges as the pipeline. The pipeline has no backpressure, so the latency check assumes nothing stalls the stream. The bench changes all inputs only on falling edges, holds `in_valid` low during reset, and keeps one operation in flight at a time. This lets each result and each sticky-flag update line up with exactly one stimulus. The illegal size codes and the out-of-range index bits are driven on purpose, because the requirements define the unit's behaviour for both.

// File: rtl/qrdmh_pkg.sv
package qrdmh_pkg;

  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_RSV_HI = 2'b11
  } esize_e;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam int LOW_W  = 64;

  function automatic logic size_legal(input logic [1:0] code);
    return (code == SZ_HALF) || (code == SZ_WORD);
  endfunction

  function automatic logic size_is_word(input logic [1:0] code);
    return code == SZ_WORD;
  endfunction

endpackage

// File: rtl/qrdmh_lane.sv
module qrdmh_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y,
  output logic          sat
);
  localparam int PW = 2 * EW;
  localparam int DW = PW + 2;
  localparam int HW = EW + 2;

  function automatic logic [HW-1:0] round_high(input logic [PW-1:0] p);
    logic [DW-1:0] d;
    d = {p[PW-1], p, 1'b0};
    d = d + (DW'(1) << (EW - 1));
    return d[DW-1:EW];
  endfunction

  function automatic logic [EW:0] clamp(input logic [HW-1:0] h);
    logic [EW:0] r;
    if ((h[HW-1:EW-1] == '0) || (h[HW-1:EW-1] == '1))
      r = {1'b0, h[EW-1:0]};
    else if (h[HW-1])
      r = {1'b1, 1'b1, {(EW-1){1'b0}}};
    else
      r = {1'b1, 1'b0, {(EW-1){1'b1}}};
    return r;
  endfunction

  logic signed [PW-1:0] prod;
  logic [HW-1:0]        hi;

  assign prod     = $signed(a) * $signed(b);
  assign hi       = round_high(prod);
  assign {sat, y} = clamp(hi);
endmodule

// File: rtl/qrdmh_opsel.sv
module qrdmh_opsel
  import qrdmh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] b_vec,
  input  logic             scalar_en,
  input  logic [1:0]       scalar_idx,
  input  logic             use_word,
  output logic [VEC_W-1:0] b_eff
);
  localparam int NH = VEC_W / HALF_W;
  localparam int NW = VEC_W / WORD_W;

  logic [LOW_W-1:0]  low;
  logic [HALF_W-1:0] pick_h;
  logic [WORD_W-1:0] pick_w;

  assign low    = b_vec[LOW_W-1:0];
  assign pick_h = low[scalar_idx*HALF_W +: HALF_W];
  assign pick_w = low[scalar_idx[0]*WORD_W +: WORD_W];

  always_comb begin
    if (!scalar_en)
      b_eff = b_vec;
    else if (use_word)
      b_eff = {NW{pick_w}};
    else
      b_eff = {NH{pick_h}};
  end
endmodule

// File: rtl/qrdmh_lanes.sv
module qrdmh_lanes
  import qrdmh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  input  logic             use_word,
  input  logic             wide,
  output logic [VEC_W-1:0] y_vec,
  output logic             any_sat
);
  localparam int NH   = VEC_W / HALF_W;
  localparam int NW   = VEC_W / WORD_W;
  localparam int NH_N = LOW_W / HALF_W;
  localparam int NW_N = LOW_W / WORD_W;

  logic [VEC_W-1:0] y_h, y_w;
  logic [NH-1:0]    sat_h;
  logic [NW-1:0]    sat_w;

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [HALF_W-1:0] ly;
    logic              ls;
    logic              act;
    qrdmh_lane #(.EW(HALF_W)) u_lane (
      .a  (a_vec[i*HALF_W +: HALF_W]),
      .b  (b_vec[i*HALF_W +: HALF_W]),
      .y  (ly),
      .sat(ls)
    );
    assign act                     = wide || (i < NH_N);
    assign y_h[i*HALF_W +: HALF_W] = act ? ly : '0;
    assign sat_h[i]                = act & ls;
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [WORD_W-1:0] ly;
    logic              ls;
    logic              act;
    qrdmh_lane #(.EW(WORD_W)) u_lane (
      .a  (a_vec[i*WORD_W +: WORD_W]),
      .b  (b_vec[i*WORD_W +: WORD_W]),
      .y  (ly),
      .sat(ls)
    );
    assign act                     = wide || (i < NW_N);
    assign y_w[i*WORD_W +: WORD_W] = act ? ly : '0;
    assign sat_w[i]                = act & ls;
  end

  assign y_vec   = use_word ? y_w : y_h;
  assign any_sat = use_word ? (|sat_w) : (|sat_h);
endmodule

// File: rtl/qrdmh_sticky.sv
module qrdmh_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/qrdmh_unit.sv
module qrdmh_unit
  import qrdmh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [1:0]       size_sel,
  input  logic             wide_sel,
  input  logic             scalar_en,
  input  logic [1:0]       scalar_idx,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_sat,
  output logic             out_bad_size,
  output logic             sat_sticky
);
  logic [VEC_W-1:0] b_sel;

  qrdmh_opsel #(.VEC_W(VEC_W)) u_opsel (
    .b_vec     (op_b),
    .scalar_en (scalar_en),
    .scalar_idx(scalar_idx),
    .use_word  (size_is_word(size_sel)),
    .b_eff     (b_sel)
  );

  // stage 1: operand capture
  logic             s1_valid;
  logic [VEC_W-1:0] s1_a, s1_b;
  logic [1:0]       s1_size;
  logic             s1_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_size  <= SZ_RSV_LO;
      s1_wide  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_a    <= op_a;
        s1_b    <= b_sel;
        s1_size <= size_sel;
        s1_wide <= wide_sel;
      end
    end
  end

  // stage 2: lane arithmetic
  logic [VEC_W-1:0] lane_y;
  logic             lane_any_sat;
  logic             s1_ok;
  logic             s2_sat_next;

  qrdmh_lanes #(.VEC_W(VEC_W)) u_lanes (
    .a_vec   (s1_a),
    .b_vec   (s1_b),
    .use_word(size_is_word(s1_size)),
    .wide    (s1_wide),
    .y_vec   (lane_y),
    .any_sat (lane_any_sat)
  );

  assign s1_ok       = size_legal(s1_size);
  assign s2_sat_next = s1_valid & s1_ok & lane_any_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_vec      <= '0;
      out_sat      <= 1'b0;
      out_bad_size <= 1'b0;
    end else begin
      out_valid    <= s1_valid;
      out_sat      <= s2_sat_next;
      out_bad_size <= s1_valid & ~s1_ok;
      if (s1_valid) out_vec <= s1_ok ? lane_y : '0;
    end
  end

  qrdmh_sticky u_sticky (
    .clk(clk),
    .rst(rst),
    .clr(sat_clr),
    .set(s2_sat_next),
    .q  (sat_sticky)
  );
endmodule

// File: rtl/qrdmh_unit_chk.sv
module qrdmh_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sat_clr,
  input logic             s1_valid,
  input logic             s2_sat_next,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_sat,
  input logic             out_bad_size,
  input logic             sat_sticky
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R9
  stage_one_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |-> (s1_valid == $past(in_valid)));

  // R9
  two_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R3
  sat_only_when_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sat |-> out_valid);

  // R6
  sat_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_sat |-> sat_sticky);

  // R6
  sticky_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_sticky) |-> (out_sat && $past(s2_sat_next)));

  // R7
  sticky_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $fell(sat_sticky)) |-> $past(sat_clr));

  // R8
  bad_size_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_bad_size |-> (out_valid && !out_sat && out_vec == '0));
endmodule

bind qrdmh_unit qrdmh_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .sat_clr     (sat_clr),
  .s1_valid    (s1_valid),
  .s2_sat_next (s2_sat_next),
  .out_valid   (out_valid),
  .out_vec     (out_vec),
  .out_sat     (out_sat),
  .out_bad_size(out_bad_size),
  .sat_sticky  (sat_sticky)
);

// File: tb/qrdmh_unit_test.sv
`timescale 1ns/1ps
module qrdmh_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   size_sel = 2'b01;
  logic         wide_sel = 1'b1, scalar_en = 1'b0;
  logic [1:0]   scalar_idx = 2'b00;
  logic         sat_clr = 1'b0;
  logic         out_valid, out_sat, out_bad_size, sat_sticky;
  logic [127:0] out_vec;

  int  n_chk = 0, n_fail = 0;
  bit  exp_sticky = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  qrdmh_unit #(.VEC_W(128)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .size_sel(size_sel), .wide_sel(wide_sel), .scalar_en(scalar_en),
    .scalar_idx(scalar_idx), .sat_clr(sat_clr), .out_valid(out_valid),
    .out_vec(out_vec), .out_sat(out_sat), .out_bad_size(out_bad_size),
    .sat_sticky(sat_sticky)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_lane(input int ew, input logic [31:0] av,
                                           input logic [31:0] bv, output bit s);
    logic signed [127:0] x, y, p, hi, lo;
    if (ew == 16) begin
      x = $signed({{112{av[15]}}, av[15:0]});
      y = $signed({{112{bv[15]}}, bv[15:0]});
    end else begin
      x = $signed({{96{av[31]}}, av});
      y = $signed({{96{bv[31]}}, bv});
    end
    p  = (2 * x * y + (128'sd1 <<< (ew - 1))) >>> ew;
    hi = (128'sd1 <<< (ew - 1)) - 128'sd1;
    lo = -(128'sd1 <<< (ew - 1));
    s  = 1'b0;
    if (p > hi) begin p = hi; s = 1'b1; end
    if (p < lo) begin p = lo; s = 1'b1; end
    return (ew == 16) ? {16'h0, p[15:0]} : p[31:0];
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] sz, input bit wide, input bit scal,
                        input logic [1:0] idx, input bit clr_mid, input string tag);
    logic [127:0] ev = '0;
    bit es = 1'b0;
    bit bad = !(sz == 2'b01 || sz == 2'b10);
    int ew = (sz == 2'b10) ? 32 : 16;
    int nl = (wide ? 128 : 64) / ew;
    logic [31:0] mask = (ew == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    int k = (ew == 32) ? int'(idx[0]) : int'(idx);
    for (int l = 0; l < nl; l++) begin
      logic [31:0] av, bv, r;
      bit s;
      av = 32'(a >> (l * ew)) & mask;
      bv = scal ? (32'(b >> (k * ew)) & mask) : (32'(b >> (l * ew)) & mask);
      r  = ref_lane(ew, av, bv, s);
      ev = ev | (128'(r) << (l * ew));
      es = es | s;
    end
    if (bad) begin ev = '0; es = 1'b0; end
    if (clr_mid) exp_sticky = es;
    else         exp_sticky = exp_sticky | es;

    @(negedge clk);
    op_a = a; op_b = b; size_sel = sz; wide_sel = wide;
    scalar_en = scal; scalar_idx = idx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = clr_mid;
    check(out_valid == 1'b0, "R9", "valid one cycle early", 128'(out_valid), 128'(0));
    @(negedge clk);
    sat_clr = 1'b0;
    check(out_valid == 1'b1, "R9", "valid after two edges", 128'(out_valid), 128'(1));
    check(out_vec == ev, tag, "result vector", out_vec, ev);
    check(out_sat == es, "R3", "per-op clamp flag", 128'(out_sat), 128'(es));
    check(out_bad_size == bad, "R8", "illegal size flag", 128'(out_bad_size), 128'(bad));
    check(sat_sticky == exp_sticky, clr_mid ? "R7" : "R6", "sticky flag",
          128'(sat_sticky), 128'(exp_sticky));
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  logic [15:0] vh [10] = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000, 16'h0001,
                          16'h0002, 16'h4000, 16'h7FFF, 16'h1234, 16'hC000};
  logic [31:0] vw [8]  = '{32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0,
                          32'h1, 32'h4000_0000, 32'h7FFF_FFFF, 32'h1234_5678};

  initial begin
    logic [127:0] a, b, mins;
    mins = {8{16'h8000}};
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_vec == 0 && sat_sticky == 0, "R9",
          "reset state", {out_vec[125:0], out_valid, sat_sticky}, 128'(0));
    rst = 1'b0;

    // R8: illegal codes with clamping operands leave sticky clear
    run_op(mins, mins, 2'b00, 1, 0, 0, 0, "R8");
    run_op(mins, mins, 2'b11, 1, 0, 0, 0, "R8");
    // R4: narrow width, clamping only in upper lanes
    a = {{4{16'h8000}}, 16'h1234, 16'h7FFF, 16'h8001, 16'h4000};
    run_op(a, a, 2'b01, 0, 0, 0, 0, "R4");
    a = {{2{32'h8000_0000}}, 32'h7FFF_FFFF, 32'h1234_5678};
    run_op(a, a, 2'b10, 0, 0, 0, 0, "R4");
    check(sat_sticky == 0, "R4", "upper lanes ignored", 128'(sat_sticky), 128'(0));

    // R1 sweep over 16-bit boundary values
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        for (int l = 0; l < 8; l++) begin
          a[l*16 +: 16] = vh[(i + l) % 10];
          b[l*16 +: 16] = vh[(j + 3 * l) % 10];
        end
        run_op(a, b, 2'b01, 1, 0, 0, 0, "R1");
      end
    // R2 sweep over 32-bit boundary values
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        for (int l = 0; l < 4; l++) begin
          a[l*32 +: 32] = vw[(i + l) % 8];
          b[l*32 +: 32] = vw[(j + 3 * l) % 8];
        end
        run_op(a, b, 2'b10, 1, 0, 0, 0, "R2");
      end
    // R1/R2 random operands, both widths
    for (int n = 0; n < 120; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      run_op(a, b, (n % 2) ? 2'b10 : 2'b01, n % 3 != 0, 0, 0, 0, (n % 2) ? "R2" : "R1");
    end
    // R5 broadcast, distinct elements, upper half different
    b = {64'h8000_8000_8000_8000, 16'h8000, 16'h7FFF, 16'hC000, 16'h1234};
    a = {8{16'h8000}};
    for (int k = 0; k < 4; k++) run_op(a, b, 2'b01, 1, 1, 2'(k), 0, "R5");
    b = {64'h8000_0000_8000_0000, 32'h8000_0000, 32'h4000_0001};
    a = {4{32'h8000_0000}};
    for (int k = 0; k < 4; k++) run_op(a, b, 2'b10, 1, 1, 2'(k), 0, "R5");

    // R7: standalone clear
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0; exp_sticky = 1'b0;
    check(sat_sticky == 0, "R7", "clear input", 128'(sat_sticky), 128'(0));
    // R6: non-clamping op keeps sticky low, clamping op sets it
    run_op({8{16'h0100}}, {8{16'h0200}}, 2'b01, 1, 0, 0, 0, "R6");
    run_op(mins, mins, 2'b01, 1, 0, 0, 0, "R6");
    run_op({8{16'h0100}}, {8{16'h0200}}, 2'b01, 1, 0, 0, 0, "R6");
    // R8: illegal size with sticky set leaves it set
    run_op(mins, mins, 2'b11, 1, 0, 0, 0, "R8");
    // R7: clear coinciding with a clamping result
    run_op(mins, mins, 2'b01, 1, 0, 0, 1, "R7");
    run_op({8{16'h0100}}, {8{16'h0200}}, 2'b01, 1, 0, 0, 1, "R7");
    run_op(mins, mins, 2'b01, 1, 0, 0, 0, "R6");
    // R7: reset clears sticky
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(sat_sticky == 0, "R7", "reset clears sticky", 128'(sat_sticky), 128'(0));
    check(out_valid == 0, "R9", "reset clears valid", 128'(out_valid), 128'(0));
    rst = 1'b0; exp_sticky = 1'b0;
    run_op(mins, mins, 2'b01, 1, 0, 0, 0, "R3");

    done = 1'b1;
    finish_up();
  end
endmodule